// File: doc/BRIEF.md
# Interrupt Arbiter and Trap Delegator

This block sits next to the control and status state of a processor hart. On every instruction boundary it decides whether a trap is taken, and which one. It merges the pending and enabled interrupt lines with the current privilege and the global interrupt enables. A synchronous exception request from the execute stage is the other source. When a trap is taken, the block computes the handler address, the cause word, the saved PC, an optional faulting address and the new values of the status fields. It also selects which register bank the surrounding logic must update: machine, supervisor or debug.

The decision about delegation has two tiers. Interrupts that are not delegated are gated by the machine enable. Only when none of them survive are the delegated ones considered, gated by the supervisor enable. A software breakpoint can be redirected into debug mode when the matching per-privilege enable is set. While debug mode is already active, every trap is sent to a fixed debug exception address and leaves all other state untouched. All results are registered and appear one cycle after the boundary strobe, as a single-cycle take pulse.

Top module: `trap_unit`

## Requirements
- R1: While reset is held, `trap_o` is 0 and every other output is 0, whatever the inputs.
- R2: A pending, enabled, non-delegated interrupt is a candidate when the privilege is below machine (encoding U=0, S=1, 3=machine), or when the privilege is machine and `mie_i` is 1.
- R3: Delegated interrupts (`irq_deleg_i` bit set) are considered only when no non-delegated candidate exists, and only when the privilege is U, or when it is S with `sie_i` set. With the privilege at machine they are never taken.
- R4: Among the candidates of the chosen tier, the lowest index wins. The interrupt cause word has bit XLEN-1 set and the index in its low bits.
- R5: A trap goes to the supervisor bank (`wr_s_o`) only if the privilege is at most S and the cause's bit is set in its delegation mask. Interrupts use `irq_deleg_i`, exceptions use `exc_deleg_i` indexed by `exc_code_i`, and codes of XLEN or above are never delegated. Every other ordinary trap goes to the machine bank (`wr_m_o`). At most one bank select is high.
- R6: A supervisor trap gives `npc_o`=`stvec_i`, `cause_o`, `epc_o`=`pc_i`, `priv_o`=S and `spie_o`= the enable of the current mode (`uie_i` in U, `sie_i` in S). It also gives `spp_o`=privilege bit 0 and `sie_o`=0, and passes the machine fields through unchanged.
- R7: A machine trap gives `npc_o`=`mtvec_i`, `cause_o`, `epc_o`=`pc_i`, `priv_o`=M and `mpie_o`= the enable of the current mode (`mie_i` in M). It also gives `mpp_o`= the prior privilege and `mie_o`=0, and passes the supervisor fields through unchanged.
- R8: An exception with code 3 (breakpoint), when `brk_en_i[priv_i]` is 1, enters debug. The outputs are `wr_dbg_o`=1, `dbg_why_o`=1, `dbg_prv_o`= the prior privilege, `epc_o`=`pc_i`, `priv_o`=M and `npc_o`=DBG_ROM. No machine or supervisor bank is written. This check comes before the one in R9.
- R9: If `dbg_why_i` is nonzero and R8 does not apply, a trap gives `npc_o`=DBG_EXC. No bank select is set, the privilege and status fields are unchanged, and the cause and epc are 0.
- R10: An exception with `exc_tval_valid_i` drives `tval_we_o`=1 and `tval_o`=`exc_tval_i`, on the same pulse as the cause. Interrupt traps never set `tval_we_o`.
- R11: When an interrupt candidate and an exception are both present on the same boundary, the interrupt is taken.
- R12: The outputs are registered: a boundary strobe in cycle N gives `trap_o` in cycle N+1 only. A strobe in the cycle that `trap_o` is high is ignored, so `trap_o` is never high for two cycles in a row. Without a strobe no trap is taken, and while `trap_o` is 0 all other outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Instruction boundary: evaluate interrupts and the exception |
| pc_i | input | XLEN | PC of the instruction at the boundary |
| priv_i | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| uie_i | input | 1 | User interrupt enable |
| sie_i | input | 1 | Supervisor interrupt enable |
| mie_i | input | 1 | Machine interrupt enable |
| spie_i | input | 1 | Current supervisor prior-enable field |
| mpie_i | input | 1 | Current machine prior-enable field |
| spp_i | input | 1 | Current supervisor prior-privilege field |
| mpp_i | input | 2 | Current machine prior-privilege field |
| irq_pend_i | input | NIRQ | Pending interrupt lines |
| irq_en_i | input | NIRQ | Per-line interrupt enable mask |
| irq_deleg_i | input | XLEN | Interrupt delegation mask |
| exc_deleg_i | input | XLEN | Exception delegation mask |
| mtvec_i | input | XLEN | Machine handler address |
| stvec_i | input | XLEN | Supervisor handler address |
| exc_valid_i | input | 1 | Synchronous exception request |
| exc_code_i | input | EXC_W | Exception code |
| exc_tval_valid_i | input | 1 | The exception carries a faulting address |
| exc_tval_i | input | XLEN | Faulting address |
| brk_en_i | input | 4 | Breakpoint-to-debug enable, indexed by privilege |
| dbg_why_i | input | 3 | Current debug cause, nonzero while in debug mode |
| trap_o | output | 1 | Single-cycle trap pulse |
| npc_o | output | XLEN | Next PC |
| priv_o | output | 2 | New privilege |
| wr_m_o | output | 1 | Write the machine trap bank |
| wr_s_o | output | 1 | Write the supervisor trap bank |
| wr_dbg_o | output | 1 | Write the debug bank (debug entry) |
| cause_o | output | XLEN | Cause word |
| epc_o | output | XLEN | Saved PC |
| tval_we_o | output | 1 | Write the faulting-address register of the chosen bank |
| tval_o | output | XLEN | Faulting address |
| sie_o | output | 1 | New supervisor interrupt enable |
| mie_o | output | 1 | New machine interrupt enable |
| spie_o | output | 1 | New supervisor prior enable |
| mpie_o | output | 1 | New machine prior enable |
| spp_o | output | 1 | New supervisor prior privilege |
| mpp_o | output | 2 | New machine prior privilege |
| dbg_why_o | output | 3 | Debug cause to record (1 = software breakpoint) |
| dbg_prv_o | output | 2 | Privilege recorded on debug entry |

## Verification
The bench builds the block with XLEN=32, NIRQ=8 and EXC_W=6. With eight lines the top index 7 can be reached alone and against lower lines, so the priority encoder is exercised at both ends. A 6-bit code field allows a code of 40, which lies above XLEN and checks that such causes can never be delegated. With a 32-bit cause word the interrupt flag sits at bit 31, where it cannot be confused with any exception code in use.

// File: rtl/trap_pkg.sv
package trap_pkg;

    typedef enum logic [1:0] {
        PRIV_U = 2'd0,
        PRIV_S = 2'd1,
        PRIV_H = 2'd2,
        PRIV_M = 2'd3
    } priv_e;

    // exception code that may be diverted into debug
    localparam int unsigned EXC_BREAK = 3;
    // debug cause recorded for a software breakpoint
    localparam logic [2:0] DBG_WHY_SWBRK = 3'd1;

    // status fields a trap may rewrite
    typedef struct packed {
        logic       sie;
        logic       mie;
        logic       spie;
        logic       mpie;
        logic       spp;
        logic [1:0] mpp;
    } stat_t;

endpackage

// File: rtl/trap_irq_pick.sv
module trap_irq_pick
    import trap_pkg::*;
#(
    parameter  int unsigned NIRQ  = 12,
    localparam int unsigned IDX_W = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NIRQ-1:0]  pend_i,
    input  logic [NIRQ-1:0]  en_i,
    input  logic [NIRQ-1:0]  deleg_i,
    input  logic [1:0]       priv_i,
    input  logic             mie_i,
    input  logic             sie_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] idx_o
);

    logic            m_ok;
    logic            s_ok;
    logic [NIRQ-1:0] live;
    logic [NIRQ-1:0] tier_m;
    logic [NIRQ-1:0] tier_s;
    logic [NIRQ-1:0] chosen;

    // machine tier open below M, or in M with its enable
    assign m_ok   = (priv_i != PRIV_M) || mie_i;
    // supervisor tier open in U, or in S with its enable
    assign s_ok   = (priv_i == PRIV_U) || ((priv_i == PRIV_S) && sie_i);
    assign live   = pend_i & en_i;
    assign tier_m = live & ~deleg_i & {NIRQ{m_ok}};
    assign tier_s = live &  deleg_i & {NIRQ{s_ok}};
    assign chosen = (|tier_m) ? tier_m : tier_s;

    always_comb begin
        hit_o = |chosen;
        idx_o = '0;
        for (int i = NIRQ - 1; i >= 0; i--) begin
            if (chosen[i]) idx_o = IDX_W'(i);
        end
    end

    // R4
    irq_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_o |-> (pend_i[idx_o] && en_i[idx_o]));

    // R3
    irq_tier_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hit_o && deleg_i[idx_o]) |-> (priv_i == PRIV_U || priv_i == PRIV_S));

endmodule

// File: rtl/trap_route.sv
module trap_route
    import trap_pkg::*;
#(
    parameter  int unsigned     XLEN    = 32,
    parameter  int unsigned     NIRQ    = 12,
    parameter  int unsigned     EXC_W   = 6,
    parameter  logic [XLEN-1:0] DBG_ROM = 'h800,
    parameter  logic [XLEN-1:0] DBG_EXC = 'h808,
    localparam int unsigned     IDX_W   = (NIRQ > 1) ? $clog2(NIRQ) : 1,
    localparam int unsigned     EXT_W   = 1 << EXC_W
) (
    input  logic             req_i,
    input  logic             hit_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [XLEN-1:0]  pc_i,
    input  logic [1:0]       priv_i,
    input  logic             uie_i,
    input  stat_t            stat_i,
    input  logic [XLEN-1:0]  irq_deleg_i,
    input  logic [XLEN-1:0]  exc_deleg_i,
    input  logic [XLEN-1:0]  mtvec_i,
    input  logic [XLEN-1:0]  stvec_i,
    input  logic             exc_valid_i,
    input  logic [EXC_W-1:0] exc_code_i,
    input  logic             tval_valid_i,
    input  logic [XLEN-1:0]  tval_i,
    input  logic [3:0]       brk_en_i,
    input  logic [2:0]       dbg_why_i,
    output logic             take_o,
    output logic [XLEN-1:0]  npc_o,
    output logic [1:0]       priv_o,
    output logic             wr_m_o,
    output logic             wr_s_o,
    output logic             wr_dbg_o,
    output logic [XLEN-1:0]  cause_o,
    output logic [XLEN-1:0]  epc_o,
    output logic             tval_we_o,
    output logic [XLEN-1:0]  tval_o,
    output stat_t            stat_o,
    output logic [2:0]       dbg_why_o,
    output logic [1:0]       dbg_prv_o
);

    logic [EXT_W-1:0] exc_deleg_ext;
    logic [XLEN-1:0]  cause;
    logic             deleg_hit;
    logic             cur_ie;
    logic             to_debug;
    logic             to_super;

    assign exc_deleg_ext = EXT_W'(exc_deleg_i);

    always_comb begin
        cause = '0;
        if (hit_i) begin
            cause[XLEN-1]      = 1'b1;
            cause[IDX_W-1:0]   = idx_i;
            deleg_hit          = irq_deleg_i[idx_i];
        end else begin
            cause              = XLEN'(exc_code_i);
            deleg_hit          = exc_deleg_ext[exc_code_i];
        end

        unique case (priv_i)
            PRIV_U:  cur_ie = uie_i;
            PRIV_S:  cur_ie = stat_i.sie;
            PRIV_M:  cur_ie = stat_i.mie;
            default: cur_ie = 1'b0;
        endcase

        to_debug = !hit_i && (exc_code_i == EXC_W'(EXC_BREAK)) && brk_en_i[priv_i];
        to_super = (priv_i == PRIV_U || priv_i == PRIV_S) && deleg_hit;
    end

    always_comb begin
        take_o    = req_i && (hit_i || exc_valid_i);
        npc_o     = '0;
        priv_o    = '0;
        wr_m_o    = 1'b0;
        wr_s_o    = 1'b0;
        wr_dbg_o  = 1'b0;
        cause_o   = '0;
        epc_o     = '0;
        tval_we_o = 1'b0;
        tval_o    = '0;
        stat_o    = '0;
        dbg_why_o = '0;
        dbg_prv_o = '0;
        if (take_o) begin
            priv_o = priv_i;
            stat_o = stat_i;
            if (to_debug) begin
                wr_dbg_o  = 1'b1;
                dbg_why_o = DBG_WHY_SWBRK;
                dbg_prv_o = priv_i;
                epc_o     = pc_i;
                priv_o    = PRIV_M;
                npc_o     = DBG_ROM;
            end else if (dbg_why_i != '0) begin
                npc_o = DBG_EXC;
            end else begin
                cause_o   = cause;
                epc_o     = pc_i;
                tval_we_o = !hit_i && tval_valid_i;
                tval_o    = (!hit_i && tval_valid_i) ? tval_i : '0;
                if (to_super) begin
                    wr_s_o      = 1'b1;
                    npc_o       = stvec_i;
                    priv_o      = PRIV_S;
                    stat_o.spie = cur_ie;
                    stat_o.spp  = priv_i[0];
                    stat_o.sie  = 1'b0;
                end else begin
                    wr_m_o      = 1'b1;
                    npc_o       = mtvec_i;
                    priv_o      = PRIV_M;
                    stat_o.mpie = cur_ie;
                    stat_o.mpp  = priv_i;
                    stat_o.mie  = 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/trap_unit.sv
module trap_unit
    import trap_pkg::*;
#(
    parameter  int unsigned     XLEN    = 32,
    parameter  int unsigned     NIRQ    = 12,
    parameter  int unsigned     EXC_W   = 6,
    parameter  logic [XLEN-1:0] DBG_ROM = 'h800,
    parameter  logic [XLEN-1:0] DBG_EXC = 'h808,
    localparam int unsigned     IDX_W   = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_i,
    input  logic [XLEN-1:0]  pc_i,
    input  logic [1:0]       priv_i,
    input  logic             uie_i,
    input  logic             sie_i,
    input  logic             mie_i,
    input  logic             spie_i,
    input  logic             mpie_i,
    input  logic             spp_i,
    input  logic [1:0]       mpp_i,
    input  logic [NIRQ-1:0]  irq_pend_i,
    input  logic [NIRQ-1:0]  irq_en_i,
    input  logic [XLEN-1:0]  irq_deleg_i,
    input  logic [XLEN-1:0]  exc_deleg_i,
    input  logic [XLEN-1:0]  mtvec_i,
    input  logic [XLEN-1:0]  stvec_i,
    input  logic             exc_valid_i,
    input  logic [EXC_W-1:0] exc_code_i,
    input  logic             exc_tval_valid_i,
    input  logic [XLEN-1:0]  exc_tval_i,
    input  logic [3:0]       brk_en_i,
    input  logic [2:0]       dbg_why_i,
    output logic             trap_o,
    output logic [XLEN-1:0]  npc_o,
    output logic [1:0]       priv_o,
    output logic             wr_m_o,
    output logic             wr_s_o,
    output logic             wr_dbg_o,
    output logic [XLEN-1:0]  cause_o,
    output logic [XLEN-1:0]  epc_o,
    output logic             tval_we_o,
    output logic [XLEN-1:0]  tval_o,
    output logic             sie_o,
    output logic             mie_o,
    output logic             spie_o,
    output logic             mpie_o,
    output logic             spp_o,
    output logic [1:0]       mpp_o,
    output logic [2:0]       dbg_why_o,
    output logic [1:0]       dbg_prv_o
);

    typedef struct packed {
        logic            take;
        logic [XLEN-1:0] npc;
        logic [1:0]      priv;
        logic            wr_m;
        logic            wr_s;
        logic            wr_dbg;
        logic [XLEN-1:0] cause;
        logic [XLEN-1:0] epc;
        logic            tval_we;
        logic [XLEN-1:0] tval;
        stat_t           st;
        logic [2:0]      dwhy;
        logic [1:0]      dprv;
    } res_t;

    res_t res_d, res_q;

    logic             req;
    logic             irq_hit;
    logic [IDX_W-1:0] irq_idx;
    stat_t            stat_in;

    logic             r_take, r_wm, r_ws, r_wd, r_tvw;
    logic [XLEN-1:0]  r_npc, r_cause, r_epc, r_tval;
    logic [1:0]       r_priv, r_dprv;
    logic [2:0]       r_dwhy;
    stat_t            r_st;

    // a strobe during the pulse cycle is dropped
    assign req     = step_i && !res_q.take;
    assign stat_in = '{sie: sie_i, mie: mie_i, spie: spie_i, mpie: mpie_i,
                       spp: spp_i, mpp: mpp_i};

    trap_irq_pick #(
        .NIRQ (NIRQ)
    ) u_pick (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pend_i  (irq_pend_i),
        .en_i    (irq_en_i),
        .deleg_i (irq_deleg_i[NIRQ-1:0]),
        .priv_i  (priv_i),
        .mie_i   (mie_i),
        .sie_i   (sie_i),
        .hit_o   (irq_hit),
        .idx_o   (irq_idx)
    );

    trap_route #(
        .XLEN    (XLEN),
        .NIRQ    (NIRQ),
        .EXC_W   (EXC_W),
        .DBG_ROM (DBG_ROM),
        .DBG_EXC (DBG_EXC)
    ) u_route (
        .req_i        (req),
        .hit_i        (irq_hit),
        .idx_i        (irq_idx),
        .pc_i         (pc_i),
        .priv_i       (priv_i),
        .uie_i        (uie_i),
        .stat_i       (stat_in),
        .irq_deleg_i  (irq_deleg_i),
        .exc_deleg_i  (exc_deleg_i),
        .mtvec_i      (mtvec_i),
        .stvec_i      (stvec_i),
        .exc_valid_i  (exc_valid_i),
        .exc_code_i   (exc_code_i),
        .tval_valid_i (exc_tval_valid_i),
        .tval_i       (exc_tval_i),
        .brk_en_i     (brk_en_i),
        .dbg_why_i    (dbg_why_i),
        .take_o       (r_take),
        .npc_o        (r_npc),
        .priv_o       (r_priv),
        .wr_m_o       (r_wm),
        .wr_s_o       (r_ws),
        .wr_dbg_o     (r_wd),
        .cause_o      (r_cause),
        .epc_o        (r_epc),
        .tval_we_o    (r_tvw),
        .tval_o       (r_tval),
        .stat_o       (r_st),
        .dbg_why_o    (r_dwhy),
        .dbg_prv_o    (r_dprv)
    );

    always_comb begin
        res_d         = '0;
        res_d.take    = r_take;
        res_d.npc     = r_npc;
        res_d.priv    = r_priv;
        res_d.wr_m    = r_wm;
        res_d.wr_s    = r_ws;
        res_d.wr_dbg  = r_wd;
        res_d.cause   = r_cause;
        res_d.epc     = r_epc;
        res_d.tval_we = r_tvw;
        res_d.tval    = r_tval;
        res_d.st      = r_st;
        res_d.dwhy    = r_dwhy;
        res_d.dprv    = r_dprv;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) res_q <= '0;
        else         res_q <= res_d;
    end

    assign trap_o    = res_q.take;
    assign npc_o     = res_q.npc;
    assign priv_o    = res_q.priv;
    assign wr_m_o    = res_q.wr_m;
    assign wr_s_o    = res_q.wr_s;
    assign wr_dbg_o  = res_q.wr_dbg;
    assign cause_o   = res_q.cause;
    assign epc_o     = res_q.epc;
    assign tval_we_o = res_q.tval_we;
    assign tval_o    = res_q.tval;
    assign sie_o     = res_q.st.sie;
    assign mie_o     = res_q.st.mie;
    assign spie_o    = res_q.st.spie;
    assign mpie_o    = res_q.st.mpie;
    assign spp_o     = res_q.st.spp;
    assign mpp_o     = res_q.st.mpp;
    assign dbg_why_o = res_q.dwhy;
    assign dbg_prv_o = res_q.dprv;

    // R12
    trap_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_o |=> !trap_o);

    // R12
    step_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !step_i |=> !trap_o);

    // R12
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !trap_o |-> (npc_o == '0 && !wr_m_o && !wr_s_o && !wr_dbg_o && !tval_we_o));

    // R5
    one_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({wr_m_o, wr_s_o, wr_dbg_o}));

    // R6
    s_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_s_o |-> (priv_o == PRIV_S && !sie_o));

    // R7
    m_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_m_o |-> (priv_o == PRIV_M && !mie_o));

    // R8
    dbg_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_dbg_o |-> (npc_o == DBG_ROM && priv_o == PRIV_M && dbg_why_o == DBG_WHY_SWBRK));

    // R10
    irq_no_tval_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trap_o && cause_o[XLEN-1]) |-> !tval_we_o);

endmodule

// File: tb/trap_unit_test.sv
`timescale 1ns/1ps
module trap_unit_test;

    localparam int unsigned XLEN  = 32;
    localparam int unsigned NIRQ  = 8;
    localparam int unsigned EXC_W = 6;
    localparam logic [31:0] ROM   = 32'h0000_0800;
    localparam logic [31:0] DEXC  = 32'h0000_0808;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic             step;
    logic [31:0]      pc;
    logic [1:0]       priv;
    logic             uie, sie, mie, spie, mpie, spp;
    logic [1:0]       mpp;
    logic [NIRQ-1:0]  pend, en;
    logic [31:0]      ideleg, edeleg, mtvec, stvec;
    logic             exv;
    logic [EXC_W-1:0] code;
    logic             tvv;
    logic [31:0]      tv;
    logic [3:0]       brk;
    logic [2:0]       dwhy_in;

    logic        trap_o, wr_m_o, wr_s_o, wr_dbg_o, tval_we_o;
    logic [31:0] npc_o, cause_o, epc_o, tval_o;
    logic [1:0]  priv_o, mpp_o, dbg_prv_o;
    logic        sie_o, mie_o, spie_o, mpie_o, spp_o;
    logic [2:0]  dbg_why_o;

    trap_unit #(
        .XLEN(XLEN), .NIRQ(NIRQ), .EXC_W(EXC_W), .DBG_ROM(ROM), .DBG_EXC(DEXC)
    ) uut (
        .clk_i(clk), .rst_ni(rst_n), .step_i(step), .pc_i(pc), .priv_i(priv),
        .uie_i(uie), .sie_i(sie), .mie_i(mie), .spie_i(spie), .mpie_i(mpie),
        .spp_i(spp), .mpp_i(mpp), .irq_pend_i(pend), .irq_en_i(en),
        .irq_deleg_i(ideleg), .exc_deleg_i(edeleg), .mtvec_i(mtvec), .stvec_i(stvec),
        .exc_valid_i(exv), .exc_code_i(code), .exc_tval_valid_i(tvv), .exc_tval_i(tv),
        .brk_en_i(brk), .dbg_why_i(dwhy_in),
        .trap_o(trap_o), .npc_o(npc_o), .priv_o(priv_o), .wr_m_o(wr_m_o),
        .wr_s_o(wr_s_o), .wr_dbg_o(wr_dbg_o), .cause_o(cause_o), .epc_o(epc_o),
        .tval_we_o(tval_we_o), .tval_o(tval_o), .sie_o(sie_o), .mie_o(mie_o),
        .spie_o(spie_o), .mpie_o(mpie_o), .spp_o(spp_o), .mpp_o(mpp_o),
        .dbg_why_o(dbg_why_o), .dbg_prv_o(dbg_prv_o)
    );

    typedef struct packed {
        logic        trap;
        logic [31:0] npc;
        logic [1:0]  priv;
        logic        wm, ws, wd;
        logic [31:0] cause, epc;
        logic        tvw;
        logic [31:0] tval;
        logic        sie, mie, spie, mpie, spp;
        logic [1:0]  mpp;
        logic [2:0]  dwhy;
        logic [1:0]  dprv;
    } rec_t;

    rec_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    prev_trap = 1'b0;
    bit    done = 1'b0;

    // reference behaviour derived from the requirements
    function automatic rec_t model();
        rec_t r;
        int   pick;
        bit   m_en, s_en, irq, deleg, ie;
        r    = '0;
        pick = -1;
        m_en = (priv != 2'd3) || mie;
        s_en = (priv == 2'd0) || (priv == 2'd1 && sie);
        for (int i = 0; i < NIRQ; i++)
            if (pick < 0 && pend[i] && en[i] && !ideleg[i] && m_en) pick = i;
        if (pick < 0)
            for (int i = 0; i < NIRQ; i++)
                if (pick < 0 && pend[i] && en[i] && ideleg[i] && s_en) pick = i;
        irq = (pick >= 0);
        if (!irq && !exv) return r;
        r.trap = 1'b1;
        r.priv = priv;
        r.sie = sie; r.mie = mie; r.spie = spie; r.mpie = mpie; r.spp = spp; r.mpp = mpp;
        deleg = irq ? ideleg[pick] : ((int'(code) < 32) ? edeleg[code[4:0]] : 1'b0);
        ie = (priv == 2'd0) ? uie : (priv == 2'd1) ? sie : (priv == 2'd3) ? mie : 1'b0;
        if (!irq && code == 6'd3 && brk[priv]) begin
            r.wd = 1'b1; r.dwhy = 3'd1; r.dprv = priv; r.epc = pc;
            r.priv = 2'd3; r.npc = ROM;
        end else if (dwhy_in != 3'd0) begin
            r.npc = DEXC;
        end else begin
            r.cause = irq ? (32'h8000_0000 | 32'(pick)) : 32'(code);
            r.epc   = pc;
            if (!irq && tvv) begin r.tvw = 1'b1; r.tval = tv; end
            if (priv <= 2'd1 && deleg) begin
                r.ws = 1'b1; r.npc = stvec; r.priv = 2'd1;
                r.spie = ie; r.spp = priv[0]; r.sie = 1'b0;
            end else begin
                r.wm = 1'b1; r.npc = mtvec; r.priv = 2'd3;
                r.mpie = ie; r.mpp = priv; r.mie = 1'b0;
            end
        end
        return r;
    endfunction

    task automatic defaults();
        pc = 32'h4000_0010; priv = 2'd3;
        uie = 0; sie = 0; mie = 0; spie = 0; mpie = 0; spp = 0; mpp = 2'd0;
        pend = '0; en = '1; ideleg = '0; edeleg = '0;
        mtvec = 32'h0000_1000; stvec = 32'h0000_2000;
        exv = 0; code = '0; tvv = 0; tv = '0; brk = '0; dwhy_in = '0;
    endtask

    // driver: one cycle, pushes what the outputs must show after the next edge
    task automatic cyc(input bit st, input string tag);
        rec_t e;
        step = st;
        e = (st && !prev_trap) ? model() : '0;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        prev_trap = e.trap;
        @(negedge clk);
    endtask

    task automatic one(input string tag);
        cyc(1'b1, tag);
        cyc(1'b0, "R12 idle after step");
    endtask

    // monitor: compares away from the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                rec_t  a, e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = {trap_o, npc_o, priv_o, wr_m_o, wr_s_o, wr_dbg_o, cause_o, epc_o,
                     tval_we_o, tval_o, sie_o, mie_o, spie_o, mpie_o, spp_o, mpp_o,
                     dbg_why_o, dbg_prv_o};
                checks++;
                if (a !== e) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", t, a, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R12 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        defaults();
        step = 1'b1; mie = 1; pend = 8'h0F; exv = 1;
        repeat (3) @(negedge clk);
        checks++;
        if (trap_o !== 1'b0 || npc_o !== 32'h0 || cause_o !== 32'h0) begin
            errors++;
            $display("FAIL R1 actual=%b/%h expected=0/0", trap_o, npc_o);
        end
        step = 1'b0;
        defaults();
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R4 R7: machine mode, enabled, two lines, lowest wins
        defaults(); mie = 1; pend = 8'b0010_1000; one("R4 lowest index M trap");
        // R2: machine mode, enable clear
        defaults(); pend = 8'h10; one("R2 M gated by mie");
        // R2: user mode ignores mie
        defaults(); priv = 0; uie = 1; pend = 8'h10; one("R2 U takes M irq");
        // R3: non-delegated tier beats delegated
        defaults(); priv = 1; sie = 1; pend = 8'b0001_0010; ideleg = 32'h2;
        one("R3 non-delegated first");
        // R3 R6: only delegated, S mode with sie
        defaults(); priv = 1; sie = 1; mpp = 2'd1; pend = 8'b0000_0110; ideleg = 32'h6;
        one("R6 S irq trap");
        // R3: S mode without sie
        defaults(); priv = 1; pend = 8'h06; ideleg = 32'h6; one("R3 S gated by sie");
        // R3: delegated never taken in M
        defaults(); mie = 1; pend = 8'h06; ideleg = 32'h6; one("R3 delegated in M");
        // R4: top line alone
        defaults(); mie = 1; pend = 8'h80; one("R4 top index");
        // R5 R6 R10: U exception delegated
        defaults(); priv = 0; uie = 1; exv = 1; code = 6'd8; edeleg = 32'h100;
        tvv = 1; tv = 32'hDEAD_BEEF; one("R10 S exc with tval");
        // R5: M exception ignores delegation
        defaults(); mie = 1; exv = 1; code = 6'd8; edeleg = 32'h100; one("R5 M not delegable");
        // R5: code above XLEN never delegated
        defaults(); priv = 0; exv = 1; code = 6'd40; edeleg = '1; one("R5 wide code");
        // R8: breakpoint into debug
        defaults(); priv = 1; sie = 1; exv = 1; code = 6'd3; brk = 4'b0010;
        one("R8 debug entry");
        // R8: enable for another privilege only
        defaults(); priv = 1; exv = 1; code = 6'd3; brk = 4'b1000; edeleg = 32'h8;
        one("R8 enable mismatch");
        // R8 before R9: breakpoint while in debug
        defaults(); exv = 1; code = 6'd3; brk = 4'b1000; dwhy_in = 3'd3;
        one("R8 over R9");
        // R9: exception while in debug
        defaults(); priv = 0; exv = 1; code = 6'd5; dwhy_in = 3'd1; tvv = 1; tv = 32'h55;
        one("R9 debug exception");
        // R11 R10: interrupt and exception together
        defaults(); priv = 0; pend = 8'h04; exv = 1; code = 6'd13; tvv = 1; tv = 32'h1234;
        one("R11 irq over exc");
        // R12: back-to-back strobe
        defaults(); mie = 1; pend = 8'h01;
        cyc(1'b1, "R12 first strobe");
        cyc(1'b1, "R12 second strobe dropped");
        cyc(1'b1, "R12 third strobe");
        cyc(1'b0, "R12 idle");
        // R12: no strobe, pending irq
        defaults(); mie = 1; pend = 8'hFF; exv = 1;
        cyc(1'b0, "R12 no strobe");
        cyc(1'b0, "R12 no strobe");

        defaults();
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule